// File: doc/BRIEF.md
# Packed Lane Integer ALU

This block is a 64-bit packed integer datapath. Each operation treats its two operands as a row of independent lanes: eight bytes, four 16-bit words, two 32-bit doublewords or one 64-bit quadword. The lane width comes only from the opcode and never from the operand data. The block covers several kinds of operation:

- lane-wise add and subtract, which can wrap or clamp to the signed or unsigned range of the lane;
- bitwise logic;
- signed narrowing packs, and interleaving unpacks of the low or high halves;
- a multiply-add that forms doubleword sums from pairs of signed word products;
- 32-bit and 64-bit moves.

A caller presents an opcode and two operands with a valid strobe. One clock later the block returns a registered result with a matching valid flag. When no valid strobe is presented, the result register keeps its last value.

Top module: `packed_lane_alu`

## Requirements
- R1: While reset is asserted (rst_n low), out_valid is 0 and out_res is all zeros.
- R2: out_valid equals in_valid delayed by one clock. out_res takes the result of an accepted operation on the next clock edge and holds it while in_valid is low.
- R3: in_op is {func[3:0], width[1:0]}, where width 0/1/2/3 selects 8/16/32/64-bit lanes. func 0 (add) and func 3 (subtract) wrap each lane modulo its own width, and no carry or borrow crosses a lane boundary.
- R4: func 1 (add) and func 4 (subtract) clamp each lane's exact signed result to that lane's signed range, for example -128..127 for bytes.
- R5: func 2 (add) and func 5 (subtract) clamp each lane's exact unsigned result to 0..2^w-1.
- R6: func 6, 7, 8 and 9 give A AND B, A OR B, A XOR B and (NOT A) AND B respectively.
- R7: func 10 packs with signed saturation. With width 1, each signed word of A and B is clamped to -128..127; A's words fill bytes 0-3 in order and B's words fill bytes 4-7. With width 2, each signed doubleword is clamped to -32768..32767; A's doublewords fill words 0-1 and B's fill words 2-3.
- R8: func 11 takes lane i of the low half of each operand and places A's lane at result lane 2i and B's lane at result lane 2i+1. func 12 does the same with the high halves. Both apply at widths 0, 1 and 2.
- R9: func 13 multiplies signed word k of A by signed word k of B. Products 0+1 go into doubleword 0 and products 2+3 go into doubleword 1, each sum wrapping modulo 2^32.
- R10: func 14 gives A[31:0] with zeros above it. func 15 gives all of A.
- R11: The width field has no effect on func 6-9 and 13-15. func 10 with width 0 or 3, and func 11/12 with width 3, give zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 6 | {func, width} opcode |
| in_a | input | DATA_W | Operand A |
| in_b | input | DATA_W | Operand B |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_res | output | DATA_W | Registered result |

## Verification
The byte lanes are swept over every A value against a spread of B values in all six add/subtract modes. Each lane is given a different offset, so lanes sit at 0x7F/0x80 and 0xFF/0x00 boundaries while their neighbours do not. A design that leaks carries across lanes, picks the wrong sign test for subtract overflow, or clamps unsigned borrows upward would corrupt exactly those lanes.

The wider lanes, the packs and the multiply-add are driven with lanes drawn from zero, one, all-ones and the signed extremes. The 0x8000 by 0x8000 product pair exposes a multiply-add that sign-extends or saturates its sum. The pack extremes expose a clamp that tests only the sign bit.

The hold, idle and undefined-width cases would show a register that loads without a strobe or a shuffle that leaks data for widths it does not define.

// File: rtl/packed_lane_alu_pkg.sv
package packed_lane_alu_pkg;

   // Operation field of the opcode (upper four bits).
   typedef enum logic [3:0] {
      F_ADD    = 4'd0,
      F_ADDS   = 4'd1,
      F_ADDUS  = 4'd2,
      F_SUB    = 4'd3,
      F_SUBS   = 4'd4,
      F_SUBUS  = 4'd5,
      F_AND    = 4'd6,
      F_OR     = 4'd7,
      F_XOR    = 4'd8,
      F_ANDN   = 4'd9,
      F_PACKSS = 4'd10,
      F_UNPKL  = 4'd11,
      F_UNPKH  = 4'd12,
      F_MADD   = 4'd13,
      F_MOV32  = 4'd14,
      F_MOV64  = 4'd15
   } func_e;

   // Lane width field of the opcode (lower two bits).
   typedef enum logic [1:0] {
      W_BYTE  = 2'd0,
      W_WORD  = 2'd1,
      W_DWORD = 2'd2,
      W_QWORD = 2'd3
   } width_e;

   // Overflow handling for lane add/subtract.
   typedef enum logic [1:0] {
      SAT_WRAP     = 2'd0,
      SAT_SIGNED   = 2'd1,
      SAT_UNSIGNED = 2'd2
   } sat_e;

   localparam int NUM_WIDTHS = 4;
   localparam int BASE_LANE_W = 8;

endpackage

// File: rtl/pla_lane_addsub.sv
module pla_lane_addsub
   import packed_lane_alu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   input  sat_e              sat_i,
   output logic [DATA_W-1:0] y_o
);

   localparam int LANES = DATA_W / LANE_W;
   localparam int MSB   = LANE_W - 1;
   localparam logic [LANE_W-1:0] UMAX = {LANE_W{1'b1}};
   localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
   localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};

   if (LANE_W < 2 || (DATA_W % LANE_W) != 0) begin : g_bad_lane
      $error("pla_lane_addsub: LANE_W must divide DATA_W");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] la, lb, raw, lane_y;
      logic [LANE_W:0]   ext;
      logic              s_ovf, u_ovf;

      assign la  = a_i[l*LANE_W +: LANE_W];
      assign lb  = b_i[l*LANE_W +: LANE_W];
      // One bit wider than the lane: the top bit is the carry or borrow,
      // and it is never fed into the neighbouring lane.
      assign ext = sub_i ? ({1'b0, la} - {1'b0, lb}) : ({1'b0, la} + {1'b0, lb});
      assign raw = ext[LANE_W-1:0];
      assign u_ovf = ext[LANE_W];
      assign s_ovf = sub_i ? ((la[MSB] != lb[MSB]) && (raw[MSB] != la[MSB]))
                           : ((la[MSB] == lb[MSB]) && (raw[MSB] != la[MSB]));

      always_comb begin
         case (sat_i)
            SAT_SIGNED:   lane_y = s_ovf ? (la[MSB] ? SMIN : SMAX) : raw;
            SAT_UNSIGNED: lane_y = u_ovf ? (sub_i ? '0 : UMAX) : raw;
            default:      lane_y = raw;
         endcase
      end

      assign y_o[l*LANE_W +: LANE_W] = lane_y;
   end

endmodule

// File: rtl/pla_lane_shuffle.sv
module pla_lane_shuffle
   import packed_lane_alu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  width_e            width_i,
   input  logic              hi_i,
   output logic [DATA_W-1:0] pack_o,
   output logic [DATA_W-1:0] unpack_o
);

   localparam int N_PACK   = 2;   // word->byte, dword->word
   localparam int N_UNPACK = 3;   // byte, word, dword interleave

   // Signed narrowing packs.
   for (genvar gi = 0; gi < N_PACK; gi++) begin : g_pack
      localparam int SRC_W = 16 << gi;
      localparam int DST_W = SRC_W / 2;
      localparam int NSRC  = DATA_W / SRC_W;
      logic [DATA_W-1:0] pv;

      function automatic logic [DST_W-1:0] narrow(input logic [SRC_W-1:0] v);
         logic [SRC_W-DST_W:0] top;
         top = v[SRC_W-1:DST_W-1];
         if ((&top) || !(|top)) narrow = v[DST_W-1:0];
         else if (v[SRC_W-1])   narrow = {1'b1, {(DST_W-1){1'b0}}};
         else                   narrow = {1'b0, {(DST_W-1){1'b1}}};
      endfunction

      for (genvar s = 0; s < NSRC; s++) begin : g_src
         assign pv[s*DST_W +: DST_W]          = narrow(a_i[s*SRC_W +: SRC_W]);
         assign pv[(s+NSRC)*DST_W +: DST_W]   = narrow(b_i[s*SRC_W +: SRC_W]);
      end
   end

   // Interleaving unpacks of the low or high halves.
   for (genvar gi = 0; gi < N_UNPACK; gi++) begin : g_unp
      localparam int LANE_W = 8 << gi;
      localparam int HALF   = (DATA_W / LANE_W) / 2;
      logic [DATA_W-1:0] uv;

      for (genvar i = 0; i < HALF; i++) begin : g_pair
         assign uv[(2*i)*LANE_W +: LANE_W] =
            hi_i ? a_i[(i+HALF)*LANE_W +: LANE_W] : a_i[i*LANE_W +: LANE_W];
         assign uv[(2*i+1)*LANE_W +: LANE_W] =
            hi_i ? b_i[(i+HALF)*LANE_W +: LANE_W] : b_i[i*LANE_W +: LANE_W];
      end
   end

   always_comb begin
      case (width_i)
         W_WORD:  pack_o = g_pack[0].pv;
         W_DWORD: pack_o = g_pack[1].pv;
         default: pack_o = '0;
      endcase
      case (width_i)
         W_BYTE:  unpack_o = g_unp[0].uv;
         W_WORD:  unpack_o = g_unp[1].uv;
         W_DWORD: unpack_o = g_unp[2].uv;
         default: unpack_o = '0;
      endcase
   end

endmodule

// File: rtl/pla_word_madd.sv
module pla_word_madd #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] y_o
);

   localparam int WORD_W = 16;
   localparam int SUM_W  = 2 * WORD_W;
   localparam int N_SUMS = DATA_W / SUM_W;

   if ((DATA_W % SUM_W) != 0) begin : g_bad_width
      $error("pla_word_madd: DATA_W must be a multiple of 32");
   end

   for (genvar k = 0; k < N_SUMS; k++) begin : g_pair
      logic signed [WORD_W-1:0] a0, a1, b0, b1;
      logic signed [SUM_W-1:0]  p0, p1;

      assign a0 = a_i[(2*k)*WORD_W   +: WORD_W];
      assign a1 = a_i[(2*k+1)*WORD_W +: WORD_W];
      assign b0 = b_i[(2*k)*WORD_W   +: WORD_W];
      assign b1 = b_i[(2*k+1)*WORD_W +: WORD_W];
      assign p0 = SUM_W'(a0) * SUM_W'(b0);
      assign p1 = SUM_W'(a1) * SUM_W'(b1);
      assign y_o[k*SUM_W +: SUM_W] = p0 + p1;
   end

endmodule

// File: rtl/packed_lane_alu.sv
module packed_lane_alu
   import packed_lane_alu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [5:0]        in_op,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_res
);

   localparam int MOVD_W  = 32;
   localparam int N_BYTES = DATA_W / BASE_LANE_W;

   if (DATA_W < 64 || (DATA_W % 64) != 0) begin : g_bad_width
      $error("packed_lane_alu: DATA_W must be a positive multiple of 64");
   end

   func_e  func;
   width_e width;
   logic   is_sub, unpack_hi;
   sat_e   sat_mode;

   assign func      = func_e'(in_op[5:2]);
   assign width     = width_e'(in_op[1:0]);
   assign is_sub    = (func == F_SUB) || (func == F_SUBS) || (func == F_SUBUS);
   assign unpack_hi = (func == F_UNPKH);

   always_comb begin
      case (func)
         F_ADDS, F_SUBS:   sat_mode = SAT_SIGNED;
         F_ADDUS, F_SUBUS: sat_mode = SAT_UNSIGNED;
         default:          sat_mode = SAT_WRAP;
      endcase
   end

   // One adder bank per lane width; the opcode picks one.
   for (genvar gi = 0; gi < NUM_WIDTHS; gi++) begin : g_as
      localparam int LW = BASE_LANE_W << gi;
      logic [DATA_W-1:0] y;
      pla_lane_addsub #(.DATA_W(DATA_W), .LANE_W(LW)) u_addsub (
         .a_i  (in_a),
         .b_i  (in_b),
         .sub_i(is_sub),
         .sat_i(sat_mode),
         .y_o  (y)
      );
   end

   logic [DATA_W-1:0] as_y, pack_y, unpack_y, madd_y, nxt_res;

   always_comb begin
      case (width)
         W_BYTE:  as_y = g_as[0].y;
         W_WORD:  as_y = g_as[1].y;
         W_DWORD: as_y = g_as[2].y;
         default: as_y = g_as[3].y;
      endcase
   end

   pla_lane_shuffle #(.DATA_W(DATA_W)) u_shuffle (
      .a_i     (in_a),
      .b_i     (in_b),
      .width_i (width),
      .hi_i    (unpack_hi),
      .pack_o  (pack_y),
      .unpack_o(unpack_y)
   );

   pla_word_madd #(.DATA_W(DATA_W)) u_madd (
      .a_i(in_a),
      .b_i(in_b),
      .y_o(madd_y)
   );

   always_comb begin
      nxt_res = '0;
      case (func)
         F_ADD, F_ADDS, F_ADDUS,
         F_SUB, F_SUBS, F_SUBUS: nxt_res = as_y;
         F_AND:    nxt_res = in_a & in_b;
         F_OR:     nxt_res = in_a | in_b;
         F_XOR:    nxt_res = in_a ^ in_b;
         F_ANDN:   nxt_res = ~in_a & in_b;
         F_PACKSS: nxt_res = pack_y;
         F_UNPKL,
         F_UNPKH:  nxt_res = unpack_y;
         F_MADD:   nxt_res = madd_y;
         F_MOV32:  nxt_res[MOVD_W-1:0] = in_a[MOVD_W-1:0];
         F_MOV64:  nxt_res = in_a;
         default:  nxt_res = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_res   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_res <= nxt_res;
      end
   end

   // R2: valid is a one-cycle copy of the strobe
   a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid)));

   // R2: idle cycles leave the result untouched
   a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_res));

   // R10: the short move never carries data above bit 31
   a_r10_mov32_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && func == F_MOV32) |=> (out_res[DATA_W-1:MOVD_W] == '0));

   // R6: XOR of equal operands gives zero
   a_r6_xor_self_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && func == F_XOR && in_a == in_b) |=> (out_res == '0));

   // R5: unsigned saturating byte add never ends below its A lane
   for (genvar l = 0; l < N_BYTES; l++) begin : g_chk_us
      a_r5_usat_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && func == F_ADDUS && width == W_BYTE) |=>
         (out_res[l*8 +: 8] >= $past(in_a[l*8 +: 8])));
   end

endmodule

// File: tb/packed_lane_alu_bench.sv
`timescale 1ns/1ps
module packed_lane_alu_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [5:0]  in_op;
   logic [63:0] in_a, in_b;
   logic        out_valid;
   logic [63:0] out_res;

   int errors = 0;
   int checks = 0;
   logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;
   logic [63:0] last_exp;

   always #10 clk = ~clk;   // 50 MHz

   packed_lane_alu u_packed_lane_alu (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_res(out_res)
   );

   function automatic logic [63:0] lane_of(input logic [63:0] v, input int w, input int k);
      logic [63:0] m;
      m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      return (v >> (k*w)) & m;
   endfunction

   function automatic logic [63:0] model(input logic [5:0] op, input logic [63:0] a, input logic [63:0] b);
      int f, ws, w, n;
      logic signed [67:0] one, mask, ua, ub, sa, sb, r, smax, smin, dmask;
      logic [63:0] y;
      f  = int'(op[5:2]);
      ws = int'(op[1:0]);
      w  = 8 << ws;
      n  = 64 / w;
      y  = '0;
      one  = 68'sd1;
      mask = (one <<< w) - one;
      smax = (one <<< (w-1)) - one;
      smin = -(one <<< (w-1));
      if (f <= 5) begin
         for (int k = 0; k < n; k++) begin
            ua = 68'(lane_of(a, w, k));
            ub = 68'(lane_of(b, w, k));
            sa = ua[w-1] ? ua - (one <<< w) : ua;
            sb = ub[w-1] ? ub - (one <<< w) : ub;
            if (f == 1 || f == 4) begin
               r = (f == 1) ? sa + sb : sa - sb;
               if (r > smax) r = smax;
               if (r < smin) r = smin;
            end else begin
               r = (f < 3) ? ua + ub : ua - ub;
               if (f == 2 || f == 5) begin
                  if (r > mask) r = mask;
                  if (r < 68'sd0) r = 68'sd0;
               end
            end
            y = y | (64'(r & mask) << (k*w));
         end
      end else if (f == 6) y = a & b;
      else if (f == 7) y = a | b;
      else if (f == 8) y = a ^ b;
      else if (f == 9) y = ~a & b;
      else if (f == 10) begin
         if (ws == 1 || ws == 2) begin
            smax  = (one <<< (w/2 - 1)) - one;
            smin  = -(one <<< (w/2 - 1));
            dmask = (one <<< (w/2)) - one;
            for (int k = 0; k < 2*n; k++) begin
               ua = 68'(lane_of((k < n) ? a : b, w, k % n));
               sa = ua[w-1] ? ua - (one <<< w) : ua;
               if (sa > smax) sa = smax;
               if (sa < smin) sa = smin;
               y = y | (64'(sa & dmask) << (k*(w/2)));
            end
         end
      end else if (f == 11 || f == 12) begin
         if (ws < 3) begin
            for (int i = 0; i < n/2; i++) begin
               y = y | (lane_of(a, w, i + ((f == 12) ? n/2 : 0)) << ((2*i)*w));
               y = y | (lane_of(b, w, i + ((f == 12) ? n/2 : 0)) << ((2*i+1)*w));
            end
         end
      end else if (f == 13) begin
         for (int k = 0; k < 2; k++) begin
            longint s;
            logic signed [15:0] x0, x1, z0, z1;
            x0 = a[32*k +: 16]; x1 = a[32*k+16 +: 16];
            z0 = b[32*k +: 16]; z1 = b[32*k+16 +: 16];
            s = longint'(x0) * longint'(z0) + longint'(x1) * longint'(z1);
            y[32*k +: 32] = s[31:0];
         end
      end else if (f == 14) y = {32'd0, a[31:0]};
      else y = a;
      return y;
   endfunction

   function automatic string tag_of(input int f);
      if (f == 0 || f == 3) return "R3";
      if (f == 1 || f == 4) return "R4";
      if (f == 2 || f == 5) return "R5";
      if (f <= 9)  return "R6";
      if (f == 10) return "R7";
      if (f <= 12) return "R8";
      if (f == 13) return "R9";
      return "R10";
   endfunction

   function automatic logic [63:0] next_rand();
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      return {seed[31:0], seed[63:32]};
   endfunction

   // Random word with some lanes forced to 0, 1, signed max/min or all ones.
   function automatic logic [63:0] mkvec(input int ws);
      int w, n;
      logic [63:0] r, v, lm, val;
      r  = next_rand();
      v  = next_rand();
      w  = 8 << ws;
      n  = 64 / w;
      lm = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      for (int k = 0; k < n; k++) begin
         case (r[k*3 +: 3])
            3'd0: val = 64'd0;
            3'd1: val = 64'd1;
            3'd2: val = lm >> 1;
            3'd3: val = lm ^ (lm >> 1);
            3'd4: val = lm;
            default: val = lane_of(v, w, k);
         endcase
         v = (v & ~(lm << (k*w))) | ((val & lm) << (k*w));
      end
      return v;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s op=%h a=%h b=%h actual=%h expected=%h", tag, in_op, in_a, in_b, act, exp);
      end
   endtask

   task automatic apply(input int f, input int ws, input logic [63:0] a, input logic [63:0] b, input string tag);
      logic [63:0] e;
      in_op    = {4'(f), 2'(ws)};
      in_a     = a;
      in_b     = b;
      in_valid = 1'b1;
      e = model(in_op, a, b);
      @(negedge clk);
      check(out_valid === 1'b1 && out_res === e, tag, out_res, e);
      last_exp = e;
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0;
      repeat (3) @(negedge clk);
      check(out_valid === 1'b0, "R1", {63'd0, out_valid}, 64'd0);
      check(out_res === 64'd0, "R1", out_res, 64'd0);
      in_valid = 1'b1; in_op = 6'h3C; in_a = '1;
      @(negedge clk);
      check(out_valid === 1'b0 && out_res === 64'd0, "R1", out_res, 64'd0);
      rst_n = 1'b1; in_valid = 1'b0;
      @(negedge clk);

      // Byte lanes: full A sweep per lane against a spread of B values.
      for (int f = 0; f < 6; f++)
         for (int i = 0; i < 256; i++)
            for (int j = 0; j < 256; j += 17) begin
               logic [63:0] a, b;
               for (int k = 0; k < 8; k++) begin
                  a[k*8 +: 8] = 8'((i + 37*k) & 255);
                  b[k*8 +: 8] = 8'((j + 91*k) & 255);
               end
               apply(f, 0, a, b, tag_of(f));
            end

      // Wider lanes with corner-heavy operands.
      for (int ws = 1; ws < 4; ws++)
         for (int f = 0; f < 6; f++)
            for (int n = 0; n < 250; n++) apply(f, ws, mkvec(ws), mkvec(ws), tag_of(f));

      // Logic ops under every width field (width has no effect: R11).
      for (int f = 6; f < 10; f++)
         for (int n = 0; n < 200; n++) apply(f, n % 4, mkvec(n % 4), mkvec((n+1) % 4), "R6/R11");
      apply(8, 0, 64'hDEAD_BEEF_0123_4567, 64'hDEAD_BEEF_0123_4567, "R6");

      // Packs: defined widths, then undefined widths give zero.
      for (int ws = 1; ws < 3; ws++)
         for (int n = 0; n < 400; n++) apply(10, ws, mkvec(ws), mkvec(ws), "R7");
      apply(10, 1, 64'h8000_7FFF_FF80_007F, 64'h0080_FF7F_0100_FEFF, "R7");
      apply(10, 0, mkvec(1), mkvec(1), "R11");
      apply(10, 3, mkvec(1), mkvec(1), "R11");

      // Unpacks.
      for (int f = 11; f < 13; f++)
         for (int ws = 0; ws < 3; ws++)
            for (int n = 0; n < 200; n++) apply(f, ws, mkvec(ws), mkvec(ws), "R8");
      apply(11, 3, mkvec(3), mkvec(3), "R11");
      apply(12, 3, mkvec(3), mkvec(3), "R11");

      // Multiply-add, including the extreme product pair.
      for (int n = 0; n < 500; n++) apply(13, n % 4, mkvec(1), mkvec(1), "R9/R11");
      apply(13, 1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, "R9");
      apply(13, 1, 64'h7FFF_8000_0001_FFFF, 64'h7FFF_7FFF_FFFF_FFFF, "R9");

      // Moves.
      for (int f = 14; f < 16; f++)
         for (int n = 0; n < 100; n++) apply(f, n % 4, mkvec(3), mkvec(3), "R10/R11");

      // Idle cycles: output holds, valid drops.
      apply(0, 0, 64'h0102_0304_0506_0708, 64'h1111_1111_1111_1111, "R2");
      in_valid = 1'b0;
      for (int n = 0; n < 3; n++) begin
         in_op = 6'h3C; in_a = next_rand(); in_b = next_rand();
         @(negedge clk);
         check(out_valid === 1'b0 && out_res === last_exp, "R2", out_res, last_exp);
      end
      apply(15, 0, 64'hFEDC_BA98_7654_3210, 64'd0, "R2");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete (actual=timeout expected=done)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule